// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Status Flags

This block turns an asynchronous serial line into characters of 8 or 9 data bits and holds the most recent one in a receive data register. The line is first passed through a two-flop synchroniser. It is then sampled on a 16x oversampling tick that comes from outside the block. Each bit is judged by a three-sample majority vote near the middle of its period. A sample that disagrees with the others marks noise.

Next to the data register sits a five-flag status register: data-full, idle-line, overrun, noise and framing error. Software reads the block through two strobes, a status read and a data read. A data read clears every flag that was set when the most recent status read was taken. A receiver-wakeup input keeps an idle line from raising the idle flag. After a flag is cleared, the idle flag cannot rise again until another character has been delivered to the data register.

The data register behaves as the output side of a stream. `rdata` is valid while `f_full` is high, and the status-read/data-read pair acts as the consumer's accept. The line cannot be back-pressured. When a character completes while the register is still full, the character is discarded and `f_overrun` is raised. While `f_overrun` is set, no character enters the register.

Top module: `uart_rx_status`

## Requirements
- R1: With `long_mode` low, a character is a low start bit, 8 data bits sent least significant first, and one stop bit. Each bit lasts 16 ticks. Within a bit, samples are taken on ticks 7, 8 and 9, and the bit value is their majority. The finished character appears on `rdata[7:0]` with `rdata[8]` = 0, and `f_full` rises at the same time.
- R2: With `long_mode` high, a character carries 9 data bits, also least significant first, and the ninth bit appears on `rdata[8]`.
- R3: `f_full` clears only on a data read that follows a status read taken while `f_full` was set. A data read with no such status read leaves `f_full` set.
- R4: `f_idle` rises once the line has been high for 10 bit times (8-bit mode) or 11 bit times (9-bit mode), counted from the mid-stop sample of the previous character. This happens only if a character has entered the data register since reset or since the last time `f_idle` was raised.
- R5: `f_idle` does not rise if `wake_hold` is high on the tick where the idle count completes.
- R6: If a character completes while `f_full` is set, `f_overrun` rises and `rdata` keeps its old value. While `f_overrun` is set, completed characters are dropped.
- R7: `f_noise` rises together with `f_full` when the three samples of the start bit, of any data bit or of the stop bit were not all equal. A noisy character that causes an overrun does not raise `f_noise`.
- R8: `f_frame` rises together with `f_full` when the stop-bit majority is 0.
- R9: A falling edge whose start-bit majority is 1 is a false start. The receiver goes back to hunting and stores nothing.
- R10: A data read clears only the flags that were set when the last status read was taken. A flag that rose after that status read stays set.
- R11: After reset, all five flags and `rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Asynchronous serial input, high when idle |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| long_mode | input | 1 | 1 = 9 data bits, 0 = 8 data bits |
| wake_hold | input | 1 | Receiver wakeup; suppresses idle-line detection |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| rdata | output | 9 | Receive data register |
| f_full | output | 1 | Data register holds an unread character |
| f_idle | output | 1 | Idle line detected |
| f_overrun | output | 1 | Character lost because the register was full |
| f_noise | output | 1 | Sample disagreement in the delivered character |
| f_frame | output | 1 | Stop bit sampled low |

## Verification
A change on `rxd` reaches the sampler two clocks later and is used on the next tick. `rdata`, `f_full`, `f_noise`, `f_frame` and `f_overrun` update two clock edges after the tick that takes the stop bit's middle sample. `f_idle` updates on the edge of the tick where the idle count completes, and flag clears take effect on the edge that samples the data read. A behavioural model in the bench follows the same edge counts and is compared against the outputs at every falling clock edge. The directed checks sample several ticks after each of these events, so they do not depend on the exact edge.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_START, ST_DATA, ST_STOP} rx_state_e;

  typedef struct packed {
    logic full;
    logic idle;
    logic ovr;
    logic noise;
    logic frame;
  } rx_flags_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame import uart_rx_pkg::*; #(
  parameter int OSR    = 16,
  parameter int CHAR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx,
  input  logic              tick,
  input  logic              long_mode,
  output logic              idle_hit,
  output logic              chr_done,
  output logic [CHAR_W-1:0] chr_data,
  output logic              chr_noise,
  output logic              chr_bad
);
  localparam int PW    = $clog2(OSR);
  localparam int BW    = $clog2(CHAR_W + 1);
  localparam int THR_L = (CHAR_W + 2) * OSR;
  localparam int THR_S = (CHAR_W + 1) * OSR;
  localparam int IW    = $clog2(THR_L + 1);
  localparam logic [PW-1:0] PH_A   = PW'(OSR / 2 - 2);
  localparam logic [PW-1:0] PH_C   = PW'(OSR / 2);
  localparam logic [BW-1:0] LAST_L = BW'(CHAR_W - 1);
  localparam logic [BW-1:0] LAST_S = BW'(CHAR_W - 2);

  rx_state_e         state;
  logic [PW-1:0]     phase;
  logic [BW-1:0]     bitno;
  logic [1:0]        votes;
  logic              lvl_q, noise_q;
  logic [CHAR_W-1:0] shreg;
  logic [IW-1:0]     idle_cnt;

  logic [2:0]    trio;
  logic          maj, unan;
  logic [IW-1:0] thr;
  logic [BW-1:0] last_bit;

  always_comb begin
    trio     = {votes, rx};
    maj      = (trio[0] & trio[1]) | (trio[0] & trio[2]) | (trio[1] & trio[2]);
    unan     = (&trio) | ~(|trio);
    thr      = long_mode ? IW'(THR_L) : IW'(THR_S);
    last_bit = long_mode ? LAST_L : LAST_S;
    idle_hit = tick && (state == ST_HUNT) && rx && (idle_cnt == thr - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_HUNT;
      phase     <= '0;
      bitno     <= '0;
      votes     <= '0;
      lvl_q     <= 1'b1;
      noise_q   <= 1'b0;
      shreg     <= '0;
      idle_cnt  <= '0;
      chr_done  <= 1'b0;
      chr_data  <= '0;
      chr_noise <= 1'b0;
      chr_bad   <= 1'b0;
    end else begin
      chr_done <= 1'b0;
      if (tick) begin
        if (state == ST_HUNT) begin
          lvl_q <= rx;
          if (!rx)                idle_cnt <= '0;
          else if (idle_cnt != thr) idle_cnt <= idle_cnt + 1'b1;
          if (lvl_q && !rx) begin
            state <= ST_START;
            phase <= '0;
          end
        end else begin
          phase <= phase + 1'b1;
          if (phase >= PH_A && phase < PH_C) votes <= {votes[0], rx};
          if (phase == PH_C) begin
            case (state)
              ST_START: begin
                if (maj) begin
                  state <= ST_HUNT;
                  lvl_q <= 1'b1;
                end else begin
                  state   <= ST_DATA;
                  bitno   <= '0;
                  noise_q <= !unan;
                  shreg   <= '0;
                end
              end
              ST_DATA: begin
                shreg[bitno] <= maj;
                noise_q      <= noise_q | !unan;
                bitno        <= bitno + 1'b1;
                if (bitno == last_bit) state <= ST_STOP;
              end
              default: begin
                state     <= ST_HUNT;
                lvl_q     <= rx;
                idle_cnt  <= '0;
                chr_done  <= 1'b1;
                chr_data  <= shreg;
                chr_noise <= noise_q | !unan;
                chr_bad   <= !maj;
              end
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags import uart_rx_pkg::*; #(
  parameter int CHAR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chr_done,
  input  logic [CHAR_W-1:0] chr_data,
  input  logic              chr_noise,
  input  logic              chr_bad,
  input  logic              idle_hit,
  input  logic              wake_hold,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [CHAR_W-1:0] rdata,
  output rx_flags_t         flags
);
  rx_flags_t flg, nxt, mask;
  logic      armed, load, idle_set;

  always_comb begin
    nxt      = data_rd ? rx_flags_t'(flg & ~mask) : flg;
    load     = chr_done && !flg.full && !flg.ovr;
    idle_set = idle_hit && armed && !wake_hold;
    if (load) begin
      nxt.full  = 1'b1;
      nxt.noise = nxt.noise | chr_noise;
      nxt.frame = nxt.frame | chr_bad;
    end else if (chr_done && flg.full) begin
      nxt.ovr = 1'b1;
    end
    if (idle_set) nxt.idle = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg   <= '0;
      mask  <= '0;
      armed <= 1'b0;
      rdata <= '0;
    end else begin
      flg <= nxt;
      if (load) rdata <= chr_data;
      if (load)          armed <= 1'b1;
      else if (idle_set) armed <= 1'b0;
      if (stat_rd)      mask <= flg;
      else if (data_rd) mask <= '0;
    end
  end

  assign flags = flg;
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status import uart_rx_pkg::*; #(
  parameter int OSR         = 16,
  parameter int CHAR_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              tick16,
  input  logic              long_mode,
  input  logic              wake_hold,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [CHAR_W-1:0] rdata,
  output logic              f_full,
  output logic              f_idle,
  output logic              f_overrun,
  output logic              f_noise,
  output logic              f_frame
);
  logic              rx_s, idle_hit, chr_done, chr_noise, chr_bad;
  logic [CHAR_W-1:0] chr_data;
  rx_flags_t         flags;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s)
  );

  uart_rx_frame #(.OSR(OSR), .CHAR_W(CHAR_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .rx(rx_s), .tick(tick16), .long_mode(long_mode),
    .idle_hit(idle_hit), .chr_done(chr_done), .chr_data(chr_data),
    .chr_noise(chr_noise), .chr_bad(chr_bad)
  );

  uart_rx_flags #(.CHAR_W(CHAR_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .chr_done(chr_done), .chr_data(chr_data),
    .chr_noise(chr_noise), .chr_bad(chr_bad), .idle_hit(idle_hit),
    .wake_hold(wake_hold), .stat_rd(stat_rd), .data_rd(data_rd),
    .rdata(rdata), .flags(flags)
  );

  assign f_full    = flags.full;
  assign f_idle    = flags.idle;
  assign f_overrun = flags.ovr;
  assign f_noise   = flags.noise;
  assign f_frame   = flags.frame;
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk #(
  parameter int CHAR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wake_hold,
  input logic              data_rd,
  input logic [CHAR_W-1:0] rdata,
  input logic              f_full,
  input logic              f_idle,
  input logic              f_overrun,
  input logic              f_noise,
  input logic              f_frame
);
  AST_FULL_NEEDS_DATA_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(f_full) |-> $past(data_rd)); // R3
  AST_IDLE_NOT_IN_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_idle) |-> !$past(wake_hold)); // R5
  AST_OVERRUN_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_overrun) |-> $past(f_full)); // R6
  AST_RDATA_HELD_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (f_full && $past(f_full)) |-> $stable(rdata)); // R6
  AST_NOISE_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_noise) |-> $rose(f_full)); // R7
  AST_FRAME_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_frame) |-> $rose(f_full)); // R8
endmodule

bind uart_rx_status uart_rx_status_chk #(.CHAR_W(CHAR_W)) u_chk (.*);

// File: tb/tb_uart_rx_status.sv
module tb_uart_rx_status;
  logic clk = 0, rst_n = 0, rxd = 1, tick16 = 0;
  logic long_mode = 0, wake_hold = 0, stat_rd = 0, data_rd = 0;
  logic [8:0] rdata;
  logic f_full, f_idle, f_overrun, f_noise, f_frame;
  int n_cmp = 0, n_bad = 0, div = 0;
  bit finished = 0;

  uart_rx_status dut (.*);

  always #2 clk = ~clk;

  always @(negedge clk) begin
    div    = (div + 1) % 4;
    tick16 = (div == 0);
  end

  // behavioural reference model
  bit m_s1, m_s2, m_lvl, m_nz, m_done, m_cn, m_cb, m_arm;
  bit [1:0] m_v;
  int m_st, m_ph, m_bit, m_sh, m_idle, m_cd, m_rd;
  bit m_full, m_idl, m_ovr, m_noise, m_frame;
  bit k_full, k_idl, k_ovr, k_noise, k_frame;

  always @(posedge clk or negedge rst_n) begin
    bit rxv, ih, maj, un, nf, ni, no, nn, nr, ld;
    int ones, thr, last;
    if (!rst_n) begin
      m_s1 <= 1; m_s2 <= 1; m_lvl <= 1; m_nz <= 0; m_done <= 0; m_cn <= 0; m_cb <= 0;
      m_arm <= 0; m_v <= 0; m_st <= 0; m_ph <= 0; m_bit <= 0; m_sh <= 0; m_idle <= 0;
      m_cd <= 0; m_rd <= 0;
      {m_full, m_idl, m_ovr, m_noise, m_frame} <= 0;
      {k_full, k_idl, k_ovr, k_noise, k_frame} <= 0;
    end else begin
      rxv = m_s2; ih = 0;
      thr  = long_mode ? 176 : 160;
      last = long_mode ? 8 : 7;
      m_s1 <= rxd; m_s2 <= m_s1; m_done <= 0;
      if (tick16) begin
        if (m_st == 0) begin
          m_lvl <= rxv;
          if (!rxv) m_idle <= 0;
          else if (m_idle != thr) m_idle <= m_idle + 1;
          if (rxv && m_idle == thr - 1) ih = 1;
          if (m_lvl && !rxv) begin m_st <= 1; m_ph <= 0; end
        end else begin
          m_ph <= (m_ph + 1) % 16;
          if (m_ph == 6 || m_ph == 7) m_v <= {m_v[0], rxv};
          if (m_ph == 8) begin
            ones = 0; ones += int'(m_v[1]); ones += int'(m_v[0]); ones += int'(rxv);
            maj = (ones >= 2); un = (ones == 0 || ones == 3);
            if (m_st == 1) begin
              if (maj) begin m_st <= 0; m_lvl <= 1; end
              else begin m_st <= 2; m_bit <= 0; m_nz <= !un; m_sh <= 0; end
            end else if (m_st == 2) begin
              if (maj) m_sh <= m_sh | (1 << m_bit);
              m_nz <= m_nz | !un; m_bit <= m_bit + 1;
              if (m_bit == last) m_st <= 3;
            end else begin
              m_st <= 0; m_lvl <= rxv; m_idle <= 0; m_done <= 1;
              m_cd <= m_sh; m_cn <= m_nz | !un; m_cb <= !maj;
            end
          end
        end
      end
      nf = m_full  & !(data_rd & k_full);
      ni = m_idl   & !(data_rd & k_idl);
      no = m_ovr   & !(data_rd & k_ovr);
      nn = m_noise & !(data_rd & k_noise);
      nr = m_frame & !(data_rd & k_frame);
      ld = m_done && !m_full && !m_ovr;
      if (ld) begin nf = 1; nn = nn | m_cn; nr = nr | m_cb; m_rd <= m_cd; m_arm <= 1; end
      else if (m_done && m_full) no = 1;
      if (ih && m_arm && !wake_hold) begin ni = 1; m_arm <= 0; end
      {m_full, m_idl, m_ovr, m_noise, m_frame} <= {nf, ni, no, nn, nr};
      if (stat_rd) {k_full, k_idl, k_ovr, k_noise, k_frame} <= {m_full, m_idl, m_ovr, m_noise, m_frame};
      else if (data_rd) {k_full, k_idl, k_ovr, k_noise, k_frame} <= 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_cmp++;
      if ({f_full, f_idle, f_overrun, f_noise, f_frame} !== {m_full, m_idl, m_ovr, m_noise, m_frame}
          || rdata !== 9'(m_rd)) begin
        n_bad++;
        $display("FAIL model compare (R1 R4 R6 R7 R8 R10) t=%0t flags=%b/%h exp=%b/%h",
                 $time, {f_full, f_idle, f_overrun, f_noise, f_frame}, rdata,
                 {m_full, m_idl, m_ovr, m_noise, m_frame}, 9'(m_rd));
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (tick16 !== 1'b1) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic drive_bit(input bit val, input bit glitch);
    rxd = val;
    wait_ticks(7);
    if (glitch) rxd = ~val;
    wait_ticks(1);
    rxd = val;
    wait_ticks(8);
  endtask

  // glitch: -1 none, 0..n-1 data bit, n = stop bit
  task automatic send_char(input int data, input int nbits, input bit stopv, input int glitch);
    drive_bit(0, 0);
    for (int i = 0; i < nbits; i++) drive_bit(data[i], glitch == i);
    drive_bit(stopv, glitch == nbits);
    rxd = 1;
  endtask

  task automatic pulse_stat();
    stat_rd = 1; @(negedge clk); stat_rd = 0; @(negedge clk);
  endtask

  task automatic pulse_data();
    data_rd = 1; @(negedge clk); data_rd = 0; @(negedge clk);
  endtask

  task automatic clear_all();
    pulse_stat(); pulse_data();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired (R1) actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R11 flags after reset", {f_full, f_idle, f_overrun, f_noise, f_frame}, 0);
    chk("R11 rdata after reset", rdata, 0);
    rst_n = 1;
    wait_ticks(20);

    send_char(8'hA5, 8, 1, -1);
    wait_ticks(2);
    chk("R1 full after 8-bit char", f_full, 1);
    chk("R1 rdata 8-bit char", rdata, 9'h0A5);
    chk("R1 clean char noise/frame", {f_noise, f_frame}, 0);
    wait_ticks(138);
    chk("R4 idle not yet at 140 ticks", f_idle, 0);
    wait_ticks(20);
    chk("R4 idle after 10 bit times", f_idle, 1);

    pulse_data();
    chk("R3 data read alone keeps full", f_full, 1);
    clear_all();
    chk("R3 status then data read clears full", f_full, 0);
    chk("R10 idle cleared by read pair", f_idle, 0);
    wait_ticks(200);
    chk("R4 idle not re-armed without char", f_idle, 0);

    wake_hold = 1;
    send_char(8'h3C, 8, 1, -1);
    clear_all();
    wait_ticks(200);
    chk("R5 idle held off by wake_hold", f_idle, 0);
    wake_hold = 0;

    long_mode = 1;
    send_char(9'h1C3, 9, 1, -1);
    wait_ticks(2);
    chk("R2 rdata 9-bit char", rdata, 9'h1C3);
    wait_ticks(158);
    chk("R4 9-bit idle not yet at 160 ticks", f_idle, 0);
    wait_ticks(15);
    chk("R4 idle after 11 bit times", f_idle, 1);
    clear_all();
    long_mode = 0;

    send_char(8'h11, 8, 1, -1);
    send_char(8'h22, 8, 1, -1);
    wait_ticks(2);
    chk("R6 overrun raised", f_overrun, 1);
    chk("R6 rdata kept on overrun", rdata, 9'h011);
    send_char(8'h33, 8, 1, 2);
    wait_ticks(2);
    chk("R7 no noise from overrun char", f_noise, 0);
    chk("R6 rdata kept while overrun", rdata, 9'h011);
    clear_all();
    chk("R6 overrun cleared by read pair", {f_full, f_overrun}, 0);
    send_char(8'h44, 8, 1, -1);
    wait_ticks(2);
    chk("R6 transfer resumes after clear", rdata, 9'h044);
    clear_all();

    send_char(8'h5A, 8, 1, 3);
    wait_ticks(2);
    chk("R7 noise on data bit", f_noise, 1);
    chk("R7 noisy bit still voted right", rdata, 9'h05A);
    clear_all();
    chk("R7 noise cleared", f_noise, 0);
    send_char(8'h81, 8, 1, 8);
    wait_ticks(2);
    chk("R7 noise on stop bit", f_noise, 1);
    clear_all();

    send_char(8'h3C, 8, 0, -1);
    wait_ticks(2);
    chk("R8 frame error on low stop", f_frame, 1);
    chk("R8 char still delivered", rdata, 9'h03C);
    clear_all();
    chk("R8 frame cleared", f_frame, 0);

    rxd = 0; wait_ticks(4); rxd = 1; wait_ticks(20);
    chk("R9 false start stores nothing", f_full, 0);
    send_char(8'hC7, 8, 1, -1);
    wait_ticks(2);
    chk("R9 receiver hunts again after false start", rdata, 9'h0C7);
    clear_all();

    send_char(8'h66, 8, 1, -1);
    pulse_stat();
    send_char(8'h77, 8, 1, -1);
    wait_ticks(2);
    pulse_data();
    chk("R10 full cleared by earlier status read", f_full, 0);
    chk("R10 later overrun survives data read", f_overrun, 1);
    clear_all();
    chk("R10 overrun cleared by fresh read pair", f_overrun, 0);

    wait_ticks(4);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule